// File: doc/BRIEF.md
# Guarded Control Register Write Sequencer

This block holds the eight-bit control register of a supervisory serial memory. Its nonvolatile fields are the watchdog period select, the array protection code and a hardware lock enable. None of them can be changed until a fixed unlock handshake has been completed. The serial bit decoder ahead of the block presents each write to the control register as a framed transaction: a start pulse, one or more byte strobes and a stop pulse. The block answers every byte with an ACK or a NACK, and it carries out a single-byte transaction when the stop arrives.

The unlock handshake has three steps. A first byte raises the write latch, a second byte arms the register, and a third byte either commits the new field values or leaves them as they were while staying armed. A commit starts a busy window of `COMMIT_CYC` cycles, which models the nonvolatile programming time. The write-protect pin together with the lock bit decides whether the protection code and the lock bit themselves may change. The protection code also drives a combinational write-permit decision for any array address.

Top module: `cgs_ctrl_guard`

## Requirements
- R1: After reset the control register reads 0x00, the busy flag is low, and every array address is writable. A lone byte sent while not busy is answered with ACK (rsp_nack low) in the cycle after its strobe.
- R2: When the register is idle (bit 1 clear), a single-byte transaction carrying 0x02 sets bit 1 (write latch) at the stop edge. The busy flag is not raised.
- R3: When only bit 1 is set, a transaction carrying exactly 0x06 sets bit 2 (arm) and bit 1 together.
- R4: When the register is armed (bits 2 and 1 set), a byte with bit 1 = 1 and bit 2 = 0 commits. Bits 6:5 take the byte's bits 6:5. Unless the hardware lock is active, bits 7, 4, 3 and 0 also take the byte's values. Bits 2 and 1 are cleared, and busy is high for COMMIT_CYC cycles. Outside a commit, bits 7, 6:5, 4, 3 and 0 never change.
- R5: When the register is armed, a byte with both bit 2 and bit 1 set leaves every field unchanged and the register stays armed.
- R6: A transaction carrying more than one byte gets NACK for the second and any later byte, and its stop changes nothing.
- R7: A read strobe has no effect on the register or on the handshake step.
- R8: A pulse on prot_wr_try clears bit 2 and keeps bit 1. The handshake then needs 0x06 again.
- R9: The hardware lock is active when wp_pin is high and bit 7 is 1. While it is active, a commit updates only bits 6:5.
- R10: With code k = {bit0, bit4, bit3}, an address is writable when k = 0 or when the value of its top three bits plus k is below 8.
- R11: While busy is high, every write byte gets NACK and its transaction has no effect.
- R12: A byte that does not match the expected step clears bits 2 and 1. This covers any byte other than 0x02 when idle, any byte other than 0x06 when latched, and any byte with bit 1 clear when armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| txn_start | input | 1 | Start of a control register write transaction |
| txn_byte_vld | input | 1 | Byte strobe |
| txn_byte | input | 8 | Byte value |
| txn_stop | input | 1 | End of the transaction |
| rd_strobe | input | 1 | A control register read took place |
| wp_pin | input | 1 | Write-protect pin level |
| prot_wr_try | input | 1 | A write to a protected array block was attempted |
| arr_addr | input | ADDR_W | Array address to judge |
| rsp_vld | output | 1 | A byte response is present |
| rsp_nack | output | 1 | 1 = NACK, 0 = ACK |
| ctrl_reg | output | 8 | Register contents |
| nv_busy | output | 1 | Nonvolatile commit in progress |
| arr_wr_ok | output | 1 | arr_addr may be written |

## Verification
The bench builds the block with COMMIT_CYC = 16 and ADDR_W = 8. The short busy window lets it check writes made during busy, the end of busy, and several complete unlock sequences in one short run. The 8-bit address keeps the top three bits easy to pick, so addresses on either side of several protection boundaries can be tested directly.

// File: rtl/cgs_pkg.sv
package cgs_pkg;
    localparam int REG_W   = 8;
    localparam int LOCK_B  = 7;
    localparam int WD_HI_B = 6;
    localparam int WD_LO_B = 5;
    localparam int BP_HI_B = 4;
    localparam int BP_MD_B = 3;
    localparam int ARM_B   = 2;
    localparam int LATCH_B = 1;
    localparam int BP_LO_B = 0;
    localparam int PCODE_W = 3;

    localparam logic [REG_W-1:0] STEP1_CODE = 8'h02;
    localparam logic [REG_W-1:0] STEP2_CODE = 8'h06;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_LATCHED = 2'd1,
        SEQ_ARMED   = 2'd2
    } seq_e;

    typedef struct packed {
        logic             in_txn;
        logic [1:0]       nbytes;
        logic             bad;
        logic [REG_W-1:0] held;
        logic             rsp_vld;
        logic             rsp_nack;
    } frm_s;
endpackage

// File: rtl/cgs_txn_framer.sv
module cgs_txn_framer
    import cgs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             txn_start,
    input  logic             byte_vld,
    input  logic [REG_W-1:0] byte_in,
    input  logic             txn_stop,
    input  logic             busy,
    output logic             rsp_vld,
    output logic             rsp_nack,
    output logic             exec,
    output logic [REG_W-1:0] exec_byte
);
    frm_s frm_d, frm_q;

    always_comb begin
        frm_d          = frm_q;
        frm_d.rsp_vld  = 1'b0;
        frm_d.rsp_nack = 1'b0;
        exec           = 1'b0;
        if (txn_start) begin
            frm_d.in_txn = 1'b1;
            frm_d.nbytes = 2'd0;
            frm_d.bad    = 1'b0;
        end else begin
            if (byte_vld) begin
                frm_d.rsp_vld = 1'b1;
                if (!frm_q.in_txn || busy || frm_q.nbytes != 2'd0) begin
                    // refused byte: poisons the whole transaction
                    frm_d.rsp_nack = 1'b1;
                    frm_d.bad      = 1'b1;
                    if (frm_q.nbytes != 2'd2) frm_d.nbytes = frm_q.nbytes + 2'd1;
                end else begin
                    frm_d.held   = byte_in;
                    frm_d.nbytes = 2'd1;
                end
            end
            if (txn_stop) begin
                exec         = frm_q.in_txn && frm_q.nbytes == 2'd1 && !frm_q.bad && !busy;
                frm_d.in_txn = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frm_q <= '0;
        else        frm_q <= frm_d;
    end

    assign rsp_vld   = frm_q.rsp_vld;
    assign rsp_nack  = frm_q.rsp_nack;
    assign exec_byte = frm_q.held;

    AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !txn_start && busy) |=> (rsp_vld && rsp_nack)); // R11

    AST_SECOND_BYTE_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !txn_start && frm_q.nbytes != 2'd0) |=> rsp_nack); // R6
endmodule

// File: rtl/cgs_commit_timer.sv
module cgs_commit_timer #(
    parameter int COMMIT_CYC = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(COMMIT_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)                   cnt_d = CW'(COMMIT_CYC);
        else if (cnt_q != '0)        cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    AST_BUSY_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R4
endmodule

// File: rtl/cgs_array_guard.sv
module cgs_array_guard #(
    parameter int ADDR_W = 13,
    parameter int PW     = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [PW-1:0]     pcode,
    output logic              wr_ok
);
    logic [PW-1:0] top_bits;
    logic [PW:0]   sum;

    always_comb begin
        top_bits = addr[ADDR_W-1 -: PW];
        sum      = {1'b0, top_bits} + {1'b0, pcode};
        wr_ok    = (pcode == '0) || !sum[PW];
    end
endmodule

// File: rtl/cgs_ctrl_guard.sv
module cgs_ctrl_guard
    import cgs_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int COMMIT_CYC = 1250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic              txn_byte_vld,
    input  logic [7:0]        txn_byte,
    input  logic              txn_stop,
    input  logic              rd_strobe,
    input  logic              wp_pin,
    input  logic              prot_wr_try,
    input  logic [ADDR_W-1:0] arr_addr,
    output logic              rsp_vld,
    output logic              rsp_nack,
    output logic [7:0]        ctrl_reg,
    output logic              nv_busy,
    output logic              arr_wr_ok
);
    logic [REG_W-1:0] creg_d, creg_q;
    logic [REG_W-1:0] ebyte;
    logic             exec, commit_go, hw_lock;
    logic [PCODE_W-1:0] pcode;
    seq_e             seq;

    cgs_txn_framer u_framer (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .byte_vld(txn_byte_vld),
        .byte_in(txn_byte), .txn_stop(txn_stop), .busy(nv_busy),
        .rsp_vld(rsp_vld), .rsp_nack(rsp_nack), .exec(exec), .exec_byte(ebyte)
    );

    cgs_commit_timer #(.COMMIT_CYC(COMMIT_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(commit_go), .busy(nv_busy)
    );

    assign pcode = {creg_q[BP_LO_B], creg_q[BP_HI_B], creg_q[BP_MD_B]};

    cgs_array_guard #(.ADDR_W(ADDR_W), .PW(PCODE_W)) u_guard (
        .addr(arr_addr), .pcode(pcode), .wr_ok(arr_wr_ok)
    );

    always_comb begin
        if (!creg_q[LATCH_B])     seq = SEQ_IDLE;
        else if (!creg_q[ARM_B])  seq = SEQ_LATCHED;
        else                      seq = SEQ_ARMED;
    end

    assign hw_lock = wp_pin & creg_q[LOCK_B];

    always_comb begin
        creg_d    = creg_q;
        commit_go = 1'b0;
        if (exec) begin
            unique case (seq)
                SEQ_IDLE: begin
                    if (ebyte == STEP1_CODE) creg_d[LATCH_B] = 1'b1;
                    else begin
                        creg_d[LATCH_B] = 1'b0;
                        creg_d[ARM_B]   = 1'b0;
                    end
                end
                SEQ_LATCHED: begin
                    creg_d[LATCH_B] = (ebyte == STEP2_CODE);
                    creg_d[ARM_B]   = (ebyte == STEP2_CODE);
                end
                SEQ_ARMED: begin
                    if (ebyte[LATCH_B] && !ebyte[ARM_B]) begin
                        commit_go        = 1'b1;
                        creg_d[WD_HI_B]  = ebyte[WD_HI_B];
                        creg_d[WD_LO_B]  = ebyte[WD_LO_B];
                        if (!hw_lock) begin
                            creg_d[LOCK_B]  = ebyte[LOCK_B];
                            creg_d[BP_HI_B] = ebyte[BP_HI_B];
                            creg_d[BP_MD_B] = ebyte[BP_MD_B];
                            creg_d[BP_LO_B] = ebyte[BP_LO_B];
                        end
                        creg_d[LATCH_B] = 1'b0;
                        creg_d[ARM_B]   = 1'b0;
                    end else if (!(ebyte[LATCH_B] && ebyte[ARM_B])) begin
                        creg_d[LATCH_B] = 1'b0;
                        creg_d[ARM_B]   = 1'b0;
                    end
                end
                default: begin
                    creg_d[LATCH_B] = 1'b0;
                    creg_d[ARM_B]   = 1'b0;
                end
            endcase
        end
        if (prot_wr_try) creg_d[ARM_B] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) creg_q <= '0;
        else        creg_q <= creg_d;
    end

    assign ctrl_reg = creg_q;

    AST_NV_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_go |=> $stable({ctrl_reg[7:3], ctrl_reg[0]})); // R4
    AST_COMMIT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        commit_go |=> (!ctrl_reg[2] && !ctrl_reg[1] && nv_busy)); // R4
    AST_READ_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !exec && !prot_wr_try) |=> $stable(ctrl_reg)); // R7
    AST_PROT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        prot_wr_try |=> !ctrl_reg[2]); // R8
    AST_HW_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_pin && ctrl_reg[7]) |=> $stable({ctrl_reg[7], ctrl_reg[4:3], ctrl_reg[0]})); // R9
    AST_NO_CODE_ALL_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_reg[4:3] == 2'b00 && !ctrl_reg[0]) |-> arr_wr_ok); // R10
endmodule

// File: tb/cgs_ctrl_guard_tb_top.sv
`timescale 1ns/1ps
module cgs_ctrl_guard_tb_top;
    localparam int AW  = 8;
    localparam int CYC = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          txn_start = 1'b0, txn_byte_vld = 1'b0, txn_stop = 1'b0;
    logic [7:0]    txn_byte = 8'h00;
    logic          rd_strobe = 1'b0, wp_pin = 1'b0, prot_wr_try = 1'b0;
    logic [AW-1:0] arr_addr = '0;
    logic          rsp_vld, rsp_nack, nv_busy, arr_wr_ok;
    logic [7:0]    ctrl_reg;

    int checks = 0;
    int errors = 0;
    bit exp_q[$];

    always #4 clk = ~clk;

    cgs_ctrl_guard #(.ADDR_W(AW), .COMMIT_CYC(CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_byte_vld(txn_byte_vld),
        .txn_byte(txn_byte), .txn_stop(txn_stop), .rd_strobe(rd_strobe), .wp_pin(wp_pin),
        .prot_wr_try(prot_wr_try), .arr_addr(arr_addr), .rsp_vld(rsp_vld),
        .rsp_nack(rsp_nack), .ctrl_reg(ctrl_reg), .nv_busy(nv_busy), .arr_wr_ok(arr_wr_ok)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // monitor: compare every response with the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && rsp_vld) begin
            if (exp_q.size() == 0) chk(1'b0, "R6 unexpected response", 1, 0);
            else begin
                bit e;
                e = exp_q.pop_front();
                chk(rsp_nack == e, "R1/R6/R11 response", rsp_nack, e);
            end
        end
    end

    task automatic send(input logic [7:0] b0, input bit n0,
                        input bit two, input logic [7:0] b1, input bit n1);
        @(negedge clk) txn_start = 1'b1;
        @(negedge clk) begin txn_start = 1'b0; txn_byte_vld = 1'b1; txn_byte = b0; exp_q.push_back(n0); end
        if (two) begin
            @(negedge clk) begin txn_byte = b1; exp_q.push_back(n1); end
        end
        @(negedge clk) begin txn_byte_vld = 1'b0; txn_stop = 1'b1; end
        @(negedge clk) txn_stop = 1'b0;
    endtask

    task automatic wr(input logic [7:0] b);
        send(b, 1'b0, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic settle();
        repeat (CYC + 2) @(negedge clk);
    endtask

    task automatic addr_chk(input logic [7:0] a, input bit exp, input string req);
        arr_addr = a;
        #1 chk(arr_wr_ok == exp, req, arr_wr_ok, exp);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctrl_reg == 8'h00, "R1 reset reg", ctrl_reg, 8'h00);
        chk(nv_busy == 1'b0, "R1 reset busy", nv_busy, 0);
        addr_chk(8'hFF, 1'b1, "R1 reset permit");

        wr(8'h02);
        chk(ctrl_reg == 8'h02, "R2 latch", ctrl_reg, 8'h02);
        chk(nv_busy == 1'b0, "R2 no busy", nv_busy, 0);
        wr(8'h06);
        chk(ctrl_reg == 8'h06, "R3 arm", ctrl_reg, 8'h06);
        wr(8'h7B);
        chk(ctrl_reg == 8'h79, "R4 commit", ctrl_reg, 8'h79);
        chk(nv_busy == 1'b1, "R4 busy", nv_busy, 1);
        send(8'h02, 1'b1, 1'b0, 8'h00, 1'b0);
        chk(ctrl_reg == 8'h79, "R11 busy write ignored", ctrl_reg, 8'h79);
        settle();
        chk(nv_busy == 1'b0, "R4 busy ends", nv_busy, 0);
        addr_chk(8'h1F, 1'b1, "R10 k7 low ok");
        addr_chk(8'h20, 1'b0, "R10 k7 blocked");

        wr(8'h02); wr(8'h06); wr(8'h06);
        chk(ctrl_reg == 8'h7F, "R5 escape keeps", ctrl_reg, 8'h7F);
        wr(8'h02);
        chk(ctrl_reg == 8'h00, "R4 clear all", ctrl_reg, 8'h00);
        settle();

        wr(8'h02);
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
        chk(ctrl_reg == 8'h02, "R7 read inert", ctrl_reg, 8'h02);
        wr(8'h06);
        chk(ctrl_reg == 8'h06, "R7 sequence survives read", ctrl_reg, 8'h06);

        send(8'h12, 1'b0, 1'b1, 8'h00, 1'b1);
        chk(ctrl_reg == 8'h06, "R6 abort", ctrl_reg, 8'h06);
        chk(nv_busy == 1'b0, "R6 no busy", nv_busy, 0);

        @(negedge clk) prot_wr_try = 1'b1;
        @(negedge clk) prot_wr_try = 1'b0;
        chk(ctrl_reg == 8'h02, "R8 disarm", ctrl_reg, 8'h02);
        wr(8'h06);
        wr(8'h12);
        chk(ctrl_reg == 8'h10, "R4 k2 commit", ctrl_reg, 8'h10);
        settle();
        addr_chk(8'hBF, 1'b1, "R10 k2 ok");
        addr_chk(8'hC0, 1'b0, "R10 k2 blocked");

        wr(8'h02); wr(8'h10);
        chk(ctrl_reg == 8'h10, "R12 wrong step2", ctrl_reg, 8'h10);
        wr(8'h02); wr(8'h06); wr(8'h10);
        chk(ctrl_reg == 8'h10, "R12 armed mismatch", ctrl_reg, 8'h10);
        wr(8'h04);
        chk(ctrl_reg == 8'h10, "R12 idle mismatch", ctrl_reg, 8'h10);

        wr(8'h02); wr(8'h06); wr(8'h82);
        chk(ctrl_reg == 8'h80, "R4 lock set", ctrl_reg, 8'h80);
        settle();
        wp_pin = 1'b1;
        wr(8'h02); wr(8'h06); wr(8'h7B);
        chk(ctrl_reg == 8'hE0, "R9 hw lock", ctrl_reg, 8'hE0);
        settle();
        wp_pin = 1'b0;
        wr(8'h02); wr(8'h06); wr(8'h02);
        chk(ctrl_reg == 8'h00, "R9 unlocked", ctrl_reg, 8'h00);
        settle();
        wp_pin = 1'b1;
        wr(8'h02); wr(8'h06); wr(8'h1B);
        chk(ctrl_reg == 8'h19, "R9 soft mode", ctrl_reg, 8'h19);
        settle();

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R1 responses drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule